// File: doc/BRIEF.md
# I2C Register Target with Gated Broadcast Address

This block is the serial register port of a small peripheral. It watches the two wires of an I2C bus with the system clock and answers as a target. It always answers its own 7-bit address. It also answers a second address shared by several devices, but only while a configuration bit allows it. A controller can therefore send one write to the shared address and start every listening device in the same bus cycle, for example by setting a trigger bit. Data moves through a small register file. The first byte of a write sets a register pointer. Each later byte lands at the pointer, which then advances. Reads return bytes starting at the pointer, and the pointer advances after each one.

The block takes part in a transfer only while the device power mode allows bus traffic. In any other mode it lets the address byte go unanswered. SDA is driven open-drain: the output means "pull low", and a released line is left to the bus pull-up.

Top module: `i2c_bcast_target`

## Requirements
- R1: With `pwr_mode` equal to 1 or 2, the address byte 0x5A followed by the R/W bit is acknowledged.
- R2: Address 0x58 is acknowledged only when bit 0 of register 1 (the broadcast enable) is 1. Otherwise it gets no ACK and the transfer has no effect on any register.
- R3: Any other address gets no ACK. The data bytes that follow it are neither acknowledged nor written.
- R4: When a byte with bit 0 set is written to register 0, `go_o` pulses high for exactly one clock. This happens the same way through either accepted address. Bit 0 of register 0 always reads back as 0. Bits 7:1 keep the written value.
- R5: The first data byte after a write address loads the pointer from its low three bits. Each later byte is written to the register at the pointer, and the pointer then increments, wrapping from 7 to 0.
- R6: For an ACK, `sda_pull_o` goes high while SCL is low and stays high through the whole high phase of the ninth clock. The pull never changes while SCL stays high.
- R7: A read returns the register at the pointer, MSB first, and the pointer increments after each byte. After the controller NACKs a byte, the target releases SDA.
- R8: A repeated START returns the target to address reception and keeps the register pointer.
- R9: `pwr_mode` is encoded as 0 = off, 1 = standby, 2 = active, 3 = other. In modes 0 and 3 no address is acknowledged.
- R10: `sda_pull_o` is low while the target is idle, after a STOP and after reset. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pwr_mode | input | 2 | Device power mode: 0 off, 1 standby, 2 active, 3 other |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| go_o | output | 1 | One-clock trigger pulse on a GO write |

## Verification
The assertions assume that SCL and SDA each hold a level for several system clocks. They also assume the controller moves SDA only while SCL is low, except to form START and STOP, and never issues START or STOP while the target holds SDA low. The bench meets these assumptions by building every bus phase from eight-clock quarter periods. Data is changed only in the middle of the low phase. A repeated START comes only after a write byte or after a NACKed read. Random transfers pick the power mode, the address, the pointer and the byte counts, and the expected ACKs, read data and GO pulses come from a register model kept in the bench.

// File: rtl/i2c_bcast_target.sv
module i2c_bcast_target #(
  parameter int NREGS = 8,              // power of two
  parameter logic [6:0] ADDR_UNIQ = 7'h5A,
  parameter logic [6:0] ADDR_BCAST = 7'h58,
  parameter int GO_REG = 0,
  parameter int CFG_REG = 1,
  localparam int PW = $clog2(NREGS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] pwr_mode,
  output logic       sda_pull_o,
  output logic       go_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic [7:0] regs [NREGS];
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic [PW-1:0] ptr;
  logic rw, first, ack_on;
  st_t state;

  wire scl_s = scl_sy[1];
  wire scl_q = scl_sy[2];
  wire sda_s = sda_sy[1];
  wire sda_q = sda_sy[2];
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire [7:0] byte_in = {shreg[6:0], sda_s};
  wire bcast_en = regs[CFG_REG][0];
  wire permitted = (pwr_mode == 2'd1) || (pwr_mode == 2'd2);
  wire addr_hit = permitted &&
                  (byte_in[7:1] == ADDR_UNIQ || (byte_in[7:1] == ADDR_BCAST && bcast_en));
  wire is_go = (ptr == PW'(GO_REG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      shreg <= '0;
      bitcnt <= '0;
      ptr <= '0;
      rw <= 1'b0;
      first <= 1'b0;
      ack_on <= 1'b0;
      sda_pull_o <= 1'b0;
      go_o <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      go_o <= 1'b0;
      if (start_ev) begin
        state <= S_ADDR;
        bitcnt <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
        state <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            shreg <= byte_in;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              rw <= sda_s;
              first <= 1'b1;
              ack_on <= 1'b0;
              state <= addr_hit ? S_AACK : S_IDLE;
            end
          end
          S_AACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_pull_o <= 1'b1;
              ack_on <= 1'b1;
            end else if (rw) begin
              shreg <= regs[ptr];
              sda_pull_o <= ~regs[ptr][7];
              bitcnt <= '0;
              state <= S_RD;
            end else begin
              sda_pull_o <= 1'b0;
              bitcnt <= '0;
              state <= S_WR;
            end
          end
          S_WR: if (scl_rise) begin
            shreg <= byte_in;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              ack_on <= 1'b0;
              state <= S_WACK;
              if (first) begin
                ptr <= byte_in[PW-1:0];
                first <= 1'b0;
              end else begin
                regs[ptr] <= is_go ? {byte_in[7:1], 1'b0} : byte_in;
                go_o <= is_go & byte_in[0];
                ptr <= ptr + 1'b1;
              end
            end
          end
          S_WACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_pull_o <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              sda_pull_o <= 1'b0;
              bitcnt <= '0;
              state <= S_WR;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                ack_on <= 1'b0;
                state <= S_RACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s) state <= S_IDLE;
              else ack_on <= 1'b1;
            end else if (scl_fall && ack_on) begin
              shreg <= regs[ptr];
              sda_pull_o <= ~regs[ptr][7];
              bitcnt <= '0;
              state <= S_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_ack_addr_ok: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_AACK |-> (shreg[7:1] == ADDR_UNIQ || (shreg[7:1] == ADDR_BCAST && bcast_en)));

  a_r9_ack_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_ADDR && state == S_AACK) |-> $past(permitted));

  a_r4_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);

  a_r6_pull_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev || stop_ev)) |-> $stable(sda_pull_o));

  a_r10_release_when_passive: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_ADDR || state == S_WR || state == S_RACK) |-> !sda_pull_o);

endmodule

// File: tb/test_i2c_bcast_target.sv
module test_i2c_bcast_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic [1:0] pwr_mode = 2'd2;
  logic sda_pull, go;
  wire sda_bus = sda_drv & ~sda_pull;

  int n_chk = 0, n_fail = 0, go_cnt = 0, go_exp = 0;
  bit done = 0;
  logic [7:0] mreg [8];
  logic [2:0] mptr = 3'd0;
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;
  always @(posedge clk) if (go) go_cnt <= go_cnt + 1;

  i2c_bcast_target i_i2c_bcast_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .pwr_mode(pwr_mode), .sda_pull_o(sda_pull), .go_o(go));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_ack(input logic [6:0] a, input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) && (a == 7'h5A || (a == 7'h58 && mreg[1][0]));
  endfunction

  task automatic i2c_start();
    sda_drv = 1'b1; w(Q); scl = 1'b1; w(Q); sda_drv = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; w(Q); scl = 1'b1; w(Q); sda_drv = 1'b1; w(2 * Q);
    chk(sda_pull == 1'b0, "R10 release after STOP", sda_pull, 0);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(Q);
    end
    sda_drv = 1'b1; w(Q); scl = 1'b1; w(1);
    a1 = ~sda_bus; w(2 * Q - 2);
    a2 = ~sda_bus; w(1); scl = 1'b0; w(Q);
    chk(a1 == a2, "R6 ACK held across high phase", a2, a1);
    acked = a1 & a2;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); b[i] = sda_bus; w(Q); scl = 1'b0;
    end
    w(Q); sda_drv = ~ack; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(Q);
    sda_drv = 1'b1;
    if (!ack) begin
      w(Q);
      chk(sda_pull == 1'b0, "R7 release after NACK", sda_pull, 0);
    end
  endtask

  task automatic model_byte(input int i);
    if (i == 0) mptr = wbuf[0][2:0];
    else begin
      if (mptr == 3'd0) begin
        if (wbuf[i][0]) go_exp++;
        mreg[0] = {wbuf[i][7:1], 1'b0};
      end else mreg[mptr] = wbuf[i];
      mptr = mptr + 3'd1;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input string req);
    bit ack, e;
    i2c_start();
    e = exp_ack(a, pwr_mode);
    wr_byte({a, 1'b0}, ack);
    chk(ack == e, req, ack, e);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);
      chk(ack == e, {req, " data ACK"}, ack, e);
      if (e) model_byte(i);
    end
    i2c_stop();
    w(2);
    chk(go_cnt == go_exp, "R4 GO pulses", go_cnt, go_exp);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] p, input int n, input string req);
    bit ack, e;
    logic [7:0] b;
    i2c_start();
    e = exp_ack(a, pwr_mode);
    wr_byte({a, 1'b0}, ack);
    chk(ack == e, req, ack, e);
    if (e) begin
      wr_byte(p, ack);
      mptr = p[2:0];
      i2c_start();
      wr_byte({a, 1'b1}, ack);
      chk(ack == 1'b1, "R8 address after repeated START", ack, 1);
      for (int i = 0; i < n; i++) begin
        rd_byte(i != n - 1, b);
        chk(b == mreg[mptr], "R7 read data", b, mreg[mptr]);
        mptr = mptr + 3'd1;
      end
    end
    i2c_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    w(4); rst_n = 1'b1; w(4);
    chk(sda_pull == 1'b0, "R10 reset pull", sda_pull, 0);
    chk(go == 1'b0, "R10 reset go", go, 0);

    pwr_mode = 2'd2;
    wbuf[0] = 8'h00; wbuf[1] = 8'h81;
    do_write(7'h58, 2, "R2 broadcast disabled");
    do_read(7'h5A, 8'h00, 2, "R1 unique read");

    wbuf[0] = 8'h01; wbuf[1] = 8'h01; wbuf[2] = 8'hA5;
    do_write(7'h5A, 3, "R1 unique write");
    wbuf[0] = 8'h00; wbuf[1] = 8'h81;
    do_write(7'h58, 2, "R2 broadcast enabled GO");
    do_read(7'h5A, 8'h00, 3, "R4 GO bit reads 0");

    i2c_start();
    wr_byte(8'h66, ack);
    chk(ack == 1'b0, "R3 foreign address", ack, 0);
    wr_byte(8'h02, ack);
    chk(ack == 1'b0, "R3 foreign data", ack, 0);
    wr_byte(8'hFF, ack);
    chk(ack == 1'b0, "R3 foreign data", ack, 0);
    i2c_stop();
    do_read(7'h5A, 8'h02, 1, "R3 register untouched");

    pwr_mode = 2'd0;
    wbuf[0] = 8'h03; wbuf[1] = 8'h77;
    do_write(7'h5A, 2, "R9 mode off");
    pwr_mode = 2'd3;
    do_write(7'h5A, 2, "R9 mode other");
    pwr_mode = 2'd1;
    do_write(7'h5A, 2, "R9 standby");
    do_read(7'h5A, 8'h03, 1, "R9 standby read");
    pwr_mode = 2'd2;

    wbuf[0] = 8'hFE; wbuf[1] = 8'h16; wbuf[2] = 8'h17; wbuf[3] = 8'h10; wbuf[4] = 8'h11;
    do_write(7'h5A, 5, "R5 pointer wrap");
    do_read(7'h5A, 8'h06, 4, "R5 wrap readback");

    i2c_start();
    wr_byte({7'h5A, 1'b0}, ack);
    wr_byte(8'h03, ack); mptr = 3'd3;
    wr_byte(8'h3C, ack); mreg[3] = 8'h3C; mptr = 3'd4;
    i2c_start();
    wr_byte({7'h5A, 1'b1}, ack);
    chk(ack == 1'b1, "R8 repeated START ACK", ack, 1);
    rd_byte(1'b0, b);
    chk(b == mreg[4], "R8 pointer kept across repeated START", b, mreg[4]);
    i2c_stop();

    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      int k, n;
      pwr_mode = 2'($urandom_range(0, 3));
      k = $urandom_range(0, 3);
      a = (k == 0) ? 7'h58 : (k == 3) ? 7'($urandom) : 7'h5A;
      n = $urandom_range(1, 3);
      if ($urandom_range(0, 1) == 1) begin
        wbuf[0] = 8'($urandom);
        for (int i = 1; i <= n; i++) wbuf[i] = 8'($urandom);
        do_write(a, n + 1, "R1 random write ACK");
      end else begin
        do_read(a, 8'($urandom_range(0, 7)), n, "R2 random read ACK");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule